// File: doc/BRIEF.md
# Receive Mailbox Identifier Matcher

This block picks which receive mailbox stores an incoming frame. Each mailbox holds a 4-bit status code and an identifier. The host writes and reads these through a simple port. When a frame's identifier arrives, the block walks the mailbox array once, from index 0 upward, one mailbox per clock. It reports either the chosen mailbox index or that no mailbox matched.

A mailbox can win only if its code says empty-and-ready and its stored identifier equals the frame's. The lowest such index wins. On a match, the winning mailbox's code becomes full and its interrupt flag bit is set. If no mailbox matches, nothing is changed and the frame is dropped.

Outside freeze mode, a host write to a mailbox during a scan removes that mailbox from the current round. If the write hits the candidate already chosen, that candidate is dropped. The walk then goes on among the mailboxes it has not yet reached. It never goes back to earlier ones.

Top module: `mbm_rx_matcher`

## Requirements
- R1: After synchronous reset, every mailbox code reads 4'b0000 (inactive) and every identifier reads 0. All flags are 0, and `busy` and `match_valid` are low.
- R2: A host write sets the addressed mailbox's code and identifier. The read port returns them from the next cycle on.
- R3: A mailbox is eligible only when its code is 4'b0100 (empty-and-ready) and its identifier equals the frame identifier. The eligible mailbox with the lowest index is chosen.
- R4: Suppose a frame is accepted at clock edge E. Then `busy` is high from E until the report cycle. `match_valid` is high for exactly one cycle, from edge E+NUM_MB to edge E+NUM_MB+1. Mailbox k is examined in the cycle that ends at edge E+k+1.
- R5: On a match, `match_found`=1 and `match_idx` gives the winner. The winner's code becomes 4'b0010 (full) and its flag bit is set. On no match, `match_found`=0, `match_idx`=0, and no code or flag changes.
- R6: `frame_valid` is ignored while `busy` is high. No second report follows and no mailbox changes.
- R7: A non-freeze host write to the current candidate, after it has been examined, drops that candidate. The search then continues among later mailboxes. If none of them matches, the result is no match.
- R8: A mailbox that becomes eligible only after the scan has passed it is not chosen in that round.
- R9: A non-freeze host write to a mailbox that the scan has not yet reached, or reaches in that same cycle, excludes it from the current round.
- R10: While `freeze` is high, host writes exclude no mailbox from the round.
- R11: A 1 on bit i of `flag_clr` clears flag i. Setting a flag wins over clearing it in the same cycle.
- R12: An exclusion lasts for one round only. The same mailbox can be chosen by the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | Freeze mode: host writes do not exclude mailboxes |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | IDX_W | Host write mailbox index |
| host_wr_code | input | 4 | Code to write |
| host_wr_id | input | ID_W | Identifier to write |
| host_rd_addr | input | IDX_W | Host read mailbox index |
| host_rd_code | output | 4 | Code of the read mailbox |
| host_rd_id | output | ID_W | Identifier of the read mailbox |
| flag_clr | input | NUM_MB | Per-mailbox flag clear |
| flags | output | NUM_MB | Per-mailbox interrupt flags |
| frame_valid | input | 1 | Frame identifier present, starts a round when idle |
| frame_id | input | ID_W | Received frame identifier |
| busy | output | 1 | Round in progress |
| match_valid | output | 1 | One-cycle result strobe |
| match_found | output | 1 | A mailbox was chosen |
| match_idx | output | IDX_W | Chosen mailbox index, 0 on no match |

## Verification
The bench aims writes at precise scan cycles.

- A write to the candidate one cycle after it was examined must let a later equal-identifier mailbox win. A design that restarts the walk, or keeps the stale winner, reports the wrong index.
- A mailbox made eligible behind the scan must stay unchosen. A design that re-examines earlier mailboxes would pick it.
- A write ahead of the scan must skip that mailbox.
- Freeze mode must keep the candidate.
- A second `frame_valid` during a round must neither trigger a report nor fill a mailbox. A design that gets the exclusion wrong for the next round fails the reuse check.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
    localparam int CODE_W = 4;
    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_INACTIVE = 4'b0000;
    localparam code_t CODE_EMPTY    = 4'b0100;
    localparam code_t CODE_FULL     = 4'b0010;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_REPORT
    } scan_state_e;

    function automatic logic mb_eligible(code_t code, logic ids_equal);
        return (code == CODE_EMPTY) && ids_equal;
    endfunction
endpackage

// File: rtl/mbm_store.sv
module mbm_store
    import mbm_pkg::*;
#(
    parameter int NUM_MB = 8,
    parameter int ID_W   = 11,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [IDX_W-1:0]  host_addr,
    input  code_t             host_wr_code,
    input  logic [ID_W-1:0]   host_wr_id,
    input  logic [IDX_W-1:0]  host_rd_addr,
    output code_t             host_rd_code,
    output logic [ID_W-1:0]   host_rd_id,
    input  logic [IDX_W-1:0]  scan_addr,
    output code_t             scan_code,
    output logic [ID_W-1:0]   scan_id,
    input  logic              commit_en,
    input  logic [IDX_W-1:0]  commit_idx,
    input  logic [NUM_MB-1:0] flag_clr,
    output logic [NUM_MB-1:0] flags
);
    code_t            code_q [NUM_MB];
    logic [ID_W-1:0]  id_q   [NUM_MB];
    logic [NUM_MB-1:0] flag_q;
    logic [NUM_MB-1:0] set_mask;

    assign set_mask = commit_en ? (NUM_MB'(1) << commit_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_MB; i++) begin
                code_q[i] <= CODE_INACTIVE;
                id_q[i]   <= '0;
            end
            flag_q <= '0;
        end else begin
            if (host_wr_en) begin
                code_q[host_addr] <= host_wr_code;
                id_q[host_addr]   <= host_wr_id;
            end
            if (commit_en) begin
                code_q[commit_idx] <= CODE_FULL;
            end
            flag_q <= (flag_q & ~flag_clr) | set_mask;
        end
    end

    assign host_rd_code = code_q[host_rd_addr];
    assign host_rd_id   = id_q[host_rd_addr];
    assign scan_code    = code_q[scan_addr];
    assign scan_id      = id_q[scan_addr];
    assign flags        = flag_q;

    // R5: a commit leaves the winner full with its flag raised
    p_commit_marks_r5: assert property (@(posedge clk) disable iff (rst)
        commit_en |=> (flag_q[$past(commit_idx)] && code_q[$past(commit_idx)] == CODE_FULL));
endmodule

// File: rtl/mbm_scan.sv
module mbm_scan
    import mbm_pkg::*;
#(
    parameter int NUM_MB = 8,
    parameter int ID_W   = 11,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    input  logic             host_wr_en,
    input  logic [IDX_W-1:0] host_addr,
    input  logic             frame_valid,
    input  logic [ID_W-1:0]  frame_id,
    output logic [IDX_W-1:0] scan_addr,
    input  code_t            scan_code,
    input  logic [ID_W-1:0]  scan_id,
    output logic             commit_en,
    output logic [IDX_W-1:0] commit_idx,
    output logic             busy,
    output logic             match_valid,
    output logic             match_found,
    output logic [IDX_W-1:0] match_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_MB - 1);

    scan_state_e       state_q;
    logic [ID_W-1:0]   fid_q;
    logic [IDX_W-1:0]  idx_q;
    logic [NUM_MB-1:0] deact_q;
    logic              cand_v_q;
    logic [IDX_W-1:0]  cand_q;
    logic              found_q;
    logic [IDX_W-1:0]  res_idx_q;

    logic              wr_deact, cand_kill, cand_live, hit, take, last;
    logic              cand_v_d;
    logic [IDX_W-1:0]  cand_d;
    logic [NUM_MB-1:0] deact_now;

    always_comb begin
        wr_deact  = host_wr_en && !freeze && (state_q == ST_SCAN);
        deact_now = deact_q | (wr_deact ? (NUM_MB'(1) << host_addr) : '0);
        cand_kill = wr_deact && cand_v_q && (host_addr == cand_q);
        cand_live = cand_v_q && !cand_kill;
        hit       = (state_q == ST_SCAN) && mb_eligible(scan_code, scan_id == fid_q)
                    && !deact_now[idx_q];
        take      = hit && !cand_live;
        cand_v_d  = cand_live || take;
        cand_d    = take ? idx_q : cand_q;
        last      = (state_q == ST_SCAN) && (idx_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            fid_q     <= '0;
            idx_q     <= '0;
            deact_q   <= '0;
            cand_v_q  <= 1'b0;
            cand_q    <= '0;
            found_q   <= 1'b0;
            res_idx_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (frame_valid) begin
                    fid_q    <= frame_id;
                    idx_q    <= '0;
                    deact_q  <= '0;
                    cand_v_q <= 1'b0;
                    state_q  <= ST_SCAN;
                end
                ST_SCAN: begin
                    deact_q  <= deact_now;
                    cand_v_q <= cand_v_d;
                    cand_q   <= cand_d;
                    idx_q    <= idx_q + 1'b1;
                    if (last) begin
                        state_q   <= ST_REPORT;
                        found_q   <= cand_v_d;
                        res_idx_q <= cand_v_d ? cand_d : '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign scan_addr   = idx_q;
    assign commit_en   = last && cand_v_d;
    assign commit_idx  = cand_d;
    assign busy        = (state_q != ST_IDLE);
    assign match_valid = (state_q == ST_REPORT);
    assign match_found = found_q;
    assign match_idx   = res_idx_q;

    // R4: result strobe lasts a single cycle
    p_one_shot_r4: assert property (@(posedge clk) disable iff (rst)
        match_valid |=> !match_valid);
    // R4: a report is always preceded by a busy scan cycle
    p_report_after_scan_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(match_valid) |-> $past(busy));
    // R5: no-match reports carry index zero
    p_nomatch_idx_r5: assert property (@(posedge clk) disable iff (rst)
        (match_valid && !match_found) |-> (match_idx == '0));
    // R7: a candidate written by the host does not survive the write
    p_kill_r7: assert property (@(posedge clk) disable iff (rst)
        cand_kill |=> !(cand_v_q && cand_q == $past(host_addr)));
    // R8: the candidate always lies behind the scan pointer
    p_single_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && cand_v_q) |-> (cand_q < idx_q));
endmodule

// File: rtl/mbm_rx_matcher.sv
module mbm_rx_matcher
    import mbm_pkg::*;
#(
    parameter int NUM_MB = 8,
    parameter int ID_W   = 11,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze,
    input  logic              host_wr_en,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [3:0]        host_wr_code,
    input  logic [ID_W-1:0]   host_wr_id,
    input  logic [IDX_W-1:0]  host_rd_addr,
    output logic [3:0]        host_rd_code,
    output logic [ID_W-1:0]   host_rd_id,
    input  logic [NUM_MB-1:0] flag_clr,
    output logic [NUM_MB-1:0] flags,
    input  logic              frame_valid,
    input  logic [ID_W-1:0]   frame_id,
    output logic              busy,
    output logic              match_valid,
    output logic              match_found,
    output logic [IDX_W-1:0]  match_idx
);
    logic [IDX_W-1:0] scan_addr;
    code_t            scan_code;
    logic [ID_W-1:0]  scan_id;
    logic             commit_en;
    logic [IDX_W-1:0] commit_idx;

    mbm_store #(.NUM_MB(NUM_MB), .ID_W(ID_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wr_code(host_wr_code), .host_wr_id(host_wr_id),
        .host_rd_addr(host_rd_addr), .host_rd_code(host_rd_code), .host_rd_id(host_rd_id),
        .scan_addr(scan_addr), .scan_code(scan_code), .scan_id(scan_id),
        .commit_en(commit_en), .commit_idx(commit_idx),
        .flag_clr(flag_clr), .flags(flags)
    );

    mbm_scan #(.NUM_MB(NUM_MB), .ID_W(ID_W), .IDX_W(IDX_W)) u_scan (
        .clk(clk), .rst(rst), .freeze(freeze),
        .host_wr_en(host_wr_en), .host_addr(host_addr),
        .frame_valid(frame_valid), .frame_id(frame_id),
        .scan_addr(scan_addr), .scan_code(scan_code), .scan_id(scan_id),
        .commit_en(commit_en), .commit_idx(commit_idx),
        .busy(busy), .match_valid(match_valid),
        .match_found(match_found), .match_idx(match_idx)
    );

    // R7: outside freeze, a host write never lands on the mailbox being committed
    p_commit_wr_r7: assert property (@(posedge clk) disable iff (rst)
        (commit_en && host_wr_en && !freeze) |-> (host_addr != commit_idx));
    // R6: a report never starts while idle
    p_report_busy_r6: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> busy);
endmodule

// File: tb/test_mbm_rx_matcher.sv
module test_mbm_rx_matcher;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 8;
    localparam int ID_W = 11;
    localparam int IW   = 3;
    localparam logic [3:0] C_INACT = 4'b0000;
    localparam logic [3:0] C_EMPTY = 4'b0100;
    localparam logic [3:0] C_FULL  = 4'b0010;

    logic clk = 1'b0, rst = 1'b1, freeze = 1'b0, host_wr_en = 1'b0, frame_valid = 1'b0;
    logic [IW-1:0] host_addr = '0, host_rd_addr = '0, match_idx;
    logic [3:0] host_wr_code = '0, host_rd_code;
    logic [ID_W-1:0] host_wr_id = '0, host_rd_id, frame_id = '0;
    logic [N-1:0] flag_clr = '0, flags;
    logic busy, match_valid, match_found;
    int errors = 0, checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbm_rx_matcher #(.NUM_MB(N), .ID_W(ID_W)) i_mbm_rx_matcher (
        .clk(clk), .rst(rst), .freeze(freeze),
        .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wr_code(host_wr_code), .host_wr_id(host_wr_id),
        .host_rd_addr(host_rd_addr), .host_rd_code(host_rd_code), .host_rd_id(host_rd_id),
        .flag_clr(flag_clr), .flags(flags),
        .frame_valid(frame_valid), .frame_id(frame_id),
        .busy(busy), .match_valid(match_valid),
        .match_found(match_found), .match_idx(match_idx)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_mb(int idx, logic [3:0] code, logic [ID_W-1:0] id);
        host_wr_en = 1'b1; host_addr = IW'(idx); host_wr_code = code; host_wr_id = id;
        cyc();
        host_wr_en = 1'b0;
    endtask

    task automatic read_code(int idx, logic [3:0] exp, string req);
        host_rd_addr = IW'(idx);
        #1;
        check(req, 32'(host_rd_code), 32'(exp));
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) write_mb(i, C_INACT, '0);
        flag_clr = '1;
        cyc();
        flag_clr = '0;
    endtask

    // Runs one round. wr_at / fv_at give the scan cycle in which a host write
    // or an extra frame_valid is driven (-1 = none).
    task automatic run_frame(logic [ID_W-1:0] fid, int wr_at, int wr_idx,
                             logic [3:0] wr_code, logic [ID_W-1:0] wr_id,
                             int fv_at, logic exp_found, int exp_idx, string req);
        frame_valid = 1'b1; frame_id = fid;
        cyc();
        frame_valid = 1'b0;
        for (int c = 0; c < N; c++) begin
            if (c == 0) check("R4 busy during scan", 32'(busy), 1);
            if (c == N-1) check("R4 no early report", 32'(match_valid), 0);
            if (c == wr_at) begin
                host_wr_en = 1'b1; host_addr = IW'(wr_idx);
                host_wr_code = wr_code; host_wr_id = wr_id;
            end
            if (c == fv_at) begin
                frame_valid = 1'b1; frame_id = fid ^ 11'h100;
            end
            cyc();
            host_wr_en = 1'b0; frame_valid = 1'b0;
        end
        check("R4 report strobe", 32'(match_valid), 1);
        check(req, 32'(match_found), 32'(exp_found));
        check(req, 32'(match_idx), exp_found ? exp_idx : 0);
        cyc();
        check("R4 strobe one cycle", 32'(match_valid), 0);
        check("R4 idle after report", 32'(busy), 0);
    endtask

    task automatic t_reset();
        check("R1 busy", 32'(busy), 0);
        check("R1 match_valid", 32'(match_valid), 0);
        check("R1 flags", 32'(flags), 0);
        for (int i = 0; i < N; i++) read_code(i, C_INACT, "R1 code");
        check("R1 id", 32'(host_rd_id), 0);
    endtask

    task automatic t_rw();
        write_mb(4, 4'b1010, 11'h3AB);
        host_rd_addr = 3'd4; #1;
        check("R2 read code", 32'(host_rd_code), 32'hA);
        check("R2 read id", 32'(host_rd_id), 32'h3AB);
        clear_all();
    endtask

    task automatic t_basic();
        write_mb(1, C_EMPTY, 11'h055);
        write_mb(2, C_EMPTY, 11'h123);
        write_mb(3, C_INACT, 11'h123);
        write_mb(5, C_EMPTY, 11'h123);
        run_frame(11'h123, -1, 0, 0, 0, -1, 1'b1, 2, "R3 lowest eligible");
        read_code(2, C_FULL, "R5 winner full");
        check("R5 flag set", 32'(flags), 32'h04);
        run_frame(11'h123, -1, 0, 0, 0, -1, 1'b1, 5, "R3 full skipped");
        check("R5 second flag", 32'(flags), 32'h24);
        flag_clr = 8'h04; cyc(); flag_clr = '0;
        check("R11 flag clear", 32'(flags), 32'h20);
        run_frame(11'h7FF, -1, 0, 0, 0, -1, 1'b0, 0, "R5 no match");
        read_code(1, C_EMPTY, "R5 no change");
        check("R5 flags unchanged", 32'(flags), 32'h20);
        clear_all();
    endtask

    task automatic t_ignore();
        write_mb(6, C_EMPTY, 11'h200);
        write_mb(7, C_EMPTY, 11'h300);
        run_frame(11'h200, -1, 0, 0, 0, 3, 1'b1, 6, "R6 first round");
        for (int c = 0; c < N + 3; c++) begin
            check("R6 no second round", 32'(match_valid | busy), 0);
            cyc();
        end
        read_code(7, C_EMPTY, "R6 mailbox untouched");
        clear_all();
    endtask

    task automatic t_invalidate();
        write_mb(1, C_EMPTY, 11'h0A1);
        write_mb(4, C_EMPTY, 11'h0A1);
        run_frame(11'h0A1, 2, 1, C_EMPTY, 11'h0A1, -1, 1'b1, 4, "R7 search continues");
        read_code(1, C_EMPTY, "R7 dropped candidate not filled");
        clear_all();
        write_mb(2, C_EMPTY, 11'h0C3);
        run_frame(11'h0C3, 5, 2, C_EMPTY, 11'h0C3, -1, 1'b0, 0, "R7 no later match");
        clear_all();
        run_frame(11'h0B2, 3, 0, C_EMPTY, 11'h0B2, -1, 1'b0, 0, "R8 passed mailbox not chosen");
        clear_all();
    endtask

    task automatic t_ahead();
        write_mb(3, C_EMPTY, 11'h0D4);
        write_mb(6, C_EMPTY, 11'h0D4);
        run_frame(11'h0D4, 1, 3, C_EMPTY, 11'h0D4, -1, 1'b1, 6, "R9 unscanned excluded");
        run_frame(11'h0D4, -1, 0, 0, 0, -1, 1'b1, 3, "R12 exclusion one round");
        clear_all();
        write_mb(2, C_EMPTY, 11'h0E5);
        write_mb(5, C_EMPTY, 11'h0E5);
        run_frame(11'h0E5, 2, 2, C_EMPTY, 11'h0E5, -1, 1'b1, 5, "R9 same-cycle write excluded");
        clear_all();
    endtask

    task automatic t_freeze();
        write_mb(1, C_EMPTY, 11'h0F6);
        write_mb(4, C_EMPTY, 11'h0F6);
        freeze = 1'b1;
        run_frame(11'h0F6, 2, 1, C_EMPTY, 11'h0F6, -1, 1'b1, 1, "R10 freeze keeps candidate");
        freeze = 1'b0;
        clear_all();
    endtask

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_rw();
        t_basic();
        t_ignore();
        t_invalidate();
        t_ahead();
        t_freeze();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule